// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes over a clocked synchronous link, least significant bit first, with one byte of buffering in front of the shifter. A host writes the next byte into a holding register and then clears the empty flag to 0. The block moves the byte into its shifter, sets the empty flag to 1 again and starts the frame, so the host can stage the following byte while the current one is still on the wire. When the empty flag is still 0 as the last bit finishes, the next frame starts on that same clock edge with no gap between frames.

The serial clock either comes from the block or from outside. With the internal source, the block drives `sck_out`. The line idles high, TxD changes on falling edges and the receiver samples on rising edges. Each bit lasts `2*HALF_DIV` system clocks. With the external source, `sck_in` is synchronised, and TxD advances on each falling edge that follows a rising edge. When no byte is waiting at the end of a frame, the block raises the transmit-end flag, TxD keeps the last bit's level and the clock line stops. Two level interrupt requests report the empty and end conditions.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset the empty flag is 1, the end flag is 1, `txd` is 1 and `sck_out` is 1.
- R2: When the block is idle and the empty flag is 0, the clock edge after that loads the holding register into the shifter. On that same edge the empty flag becomes 1, the end flag becomes 0 and `txd` shows bit 0.
- R3: `irq_txe` equals the empty flag ANDed with `txe_ie`. It therefore rises on the load edge when enabled.
- R4: Bits leave on `txd` in order from bit 0 to bit 7. With the internal source, each bit is stable across the rising edge of `sck_out`.
- R5: With the internal source (`ext_clk_sel`=0), `sck_out` falls on the load edge and gives exactly 8 pulses per frame, each of period `2*HALF_DIV` clocks. The end flag rises `16*HALF_DIV` clocks after the load edge.
- R6: When the empty flag is 0 at the falling edge that ends bit 7, the next byte's bit 0 appears on that same edge. The end flag stays 0 and two frames take `32*HALF_DIV` clocks.
- R7: When the empty flag is 1 at the end of bit 7, the end flag becomes 1. After that, `txd` holds bit 7 and `sck_out` stays high until the next load.
- R8: `irq_tend` equals the end flag ANDed with `tend_ie`.
- R9: With the external source (`ext_clk_sel`=1), `txd` moves to the next bit only on a falling edge of `sck_in` that follows a rising edge since the last move. `sck_out` stays at 1 and nothing advances while `sck_in` is still.
- R10: Writing the holding register while a frame is in progress does not change that frame. A write that is not followed by clearing the empty flag starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr_we | input | 1 | Write strobe for the holding register |
| dr_wdata | input | DATA_W | Byte written to the holding register |
| empty_clr | input | 1 | Strobe that clears the empty flag to 0 |
| txe_ie | input | 1 | Enable for the empty interrupt |
| tend_ie | input | 1 | Enable for the end interrupt |
| ext_clk_sel | input | 1 | 0 selects the internal clock, 1 selects the external clock |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internal serial clock, idles high |
| txd | output | 1 | Serial data out |
| empty_flag | output | 1 | 1 when the holding register may be rewritten |
| end_flag | output | 1 | 1 when transmission has stopped |
| irq_txe | output | 1 | Empty interrupt request (level) |
| irq_tend | output | 1 | End interrupt request (level) |

## Verification
A wrong bit counter shows up as a wrong pulse count on `sck_out`, or as an end flag that rises on the wrong cycle. The bench counts the exact cycle of the end flag from the load edge, so a counter that is off by one is caught within a single frame. A wrong decision at the last bit shows on the same edge that ends bit 7. Either the end flag rises during a back-to-back transfer, or TxD fails to show the new bit 0. In external mode, a fault in the edge detector makes TxD move before the receiving edge, and the bench detects this when it samples the bit that follows.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic {
    SCK_INTERNAL = 1'b0,
    SCK_EXTERNAL = 1'b1
  } sck_src_e;
endpackage

// File: rtl/sst_tick.sv
// Half-period timer for the internal serial clock.
module sst_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (run)  cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sst_edge.sv
// Synchroniser and edge detector for the external serial clock.
module sst_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sck_in};
      prev_q <= sync_q[STAGES-1];
    end
  end
endmodule

// File: rtl/sst_shift.sv
// Shift register, bit counter and serial clock state.
module sst_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              drive_sck,
  output logic              txd,
  output logic              sck,
  output logic              active,
  output logic              last_fall
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              smp_q, smp_d;
  logic              sck_q, sck_d;

  assign txd       = sh_q[0];
  assign sck       = sck_q;
  assign active    = act_q;
  assign last_fall = act_q && fall_ev && smp_q && (cnt_q == LAST);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    smp_d = smp_q;
    sck_d = sck_q;
    if (load) begin
      sh_d  = load_data;
      cnt_d = '0;
      act_d = 1'b1;
      smp_d = 1'b0;
      sck_d = drive_sck ? 1'b0 : 1'b1;
    end else if (act_q) begin
      if (rise_ev) begin
        smp_d = 1'b1;
        if (drive_sck) sck_d = 1'b1;
      end else if (fall_ev && smp_q) begin
        if (cnt_q == LAST) begin
          act_d = 1'b0;
        end else begin
          sh_d  = sh_q >> 1;
          cnt_d = cnt_q + 1'b1;
          smp_d = 1'b0;
          if (drive_sck) sck_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
      act_q <= 1'b0;
      smp_q <= 1'b0;
      sck_q <= 1'b1;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
      smp_q <= smp_d;
      sck_q <= sck_d;
    end
  end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dr_we,
  input  logic [DATA_W-1:0] dr_wdata,
  input  logic              empty_clr,
  input  logic              txe_ie,
  input  logic              tend_ie,
  input  logic              ext_clk_sel,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              txd,
  output logic              empty_flag,
  output logic              end_flag,
  output logic              irq_txe,
  output logic              irq_tend
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sck_src_e          src;
  logic              drive_sck;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              empty_q, empty_d;
  logic              end_q, end_d;
  logic              load, active, last_fall;
  logic              tick, ext_rise, ext_fall, rise_ev, fall_ev;

  assign src       = sck_src_e'(ext_clk_sel);
  assign drive_sck = (src == SCK_INTERNAL);

  sst_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_int_n),
    .run(active && drive_sck), .restart(load), .tick(tick)
  );

  sst_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .sck_in(sck_in),
    .rise(ext_rise), .fall(ext_fall)
  );

  assign rise_ev = drive_sck ? (tick && !sck_out) : ext_rise;
  assign fall_ev = drive_sck ? (tick &&  sck_out) : ext_fall;

  // a waiting byte goes out when idle or at the edge ending the last bit
  assign load = !empty_q && (!active || last_fall);

  sst_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .load(load), .load_data(hold_q),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .drive_sck(drive_sck),
    .txd(txd), .sck(sck_out), .active(active), .last_fall(last_fall)
  );

  always_comb begin
    hold_d  = dr_we ? dr_wdata : hold_q;
    empty_d = empty_q;
    end_d   = end_q;
    if (load) begin
      empty_d = 1'b1;
      end_d   = 1'b0;
    end else begin
      if (empty_clr)            empty_d = 1'b0;
      if (last_fall && empty_q) end_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else begin
      hold_q  <= hold_d;
      empty_q <= empty_d;
      end_q   <= end_d;
    end
  end

  assign empty_flag = empty_q;
  assign end_flag   = end_q;
  assign irq_txe    = empty_q & txe_ie;
  assign irq_tend   = end_q & tend_ie;
endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_clk_sel,
  input logic sck_out,
  input logic txd,
  input logic empty_flag,
  input logic end_flag
);
  assert_end_needs_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> empty_flag);

  assert_load_sets_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(end_flag) |-> empty_flag);

  assert_hold_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag |=> (!end_flag || ($stable(txd) && $stable(sck_out))));

  assert_sck_quiet_when_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_sel && !$stable(sck_out)) |-> !end_flag);

  assert_ext_sck_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clk_sel |-> sck_out);

  assert_refill_starts_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty_flag) |-> !end_flag);
endmodule

bind sync_ser_tx sst_tx_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .ext_clk_sel(ext_clk_sel), .sck_out(sck_out),
  .txd(txd), .empty_flag(empty_flag), .end_flag(end_flag)
);

// File: tb/sync_ser_tx_bench.sv
module sync_ser_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int H  = 2;
  localparam int NV = 6;
  // {data byte, expected held level after the frame}
  localparam logic [8:0] VEC [NV] = '{
    {8'hA5, 1'b1}, {8'h01, 1'b0}, {8'h80, 1'b1},
    {8'hFF, 1'b1}, {8'h00, 1'b0}, {8'h3C, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dr_we = 1'b0;
  logic [DW-1:0] dr_wdata = '0;
  logic empty_clr = 1'b0, txe_ie = 1'b0, tend_ie = 1'b0;
  logic ext_clk_sel = 1'b0, sck_in = 1'b1;
  logic sck_out, txd, empty_flag, end_flag, irq_txe, irq_tend;

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] cap = '0;
  int pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_ser_tx #(.DATA_W(DW), .HALF_DIV(H), .SYNC_STAGES(2)) u_sync_ser_tx (
    .clk(clk), .rst_n(rst_n), .dr_we(dr_we), .dr_wdata(dr_wdata),
    .empty_clr(empty_clr), .txe_ie(txe_ie), .tend_ie(tend_ie),
    .ext_clk_sel(ext_clk_sel), .sck_in(sck_in), .sck_out(sck_out),
    .txd(txd), .empty_flag(empty_flag), .end_flag(end_flag),
    .irq_txe(irq_txe), .irq_tend(irq_tend)
  );

  // receiver model: sample on rising serial clock
  always @(posedge sck_out) begin
    cap = {txd, cap[15:1]};
    pulses++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic post(input logic [DW-1:0] b);
    @(negedge clk); dr_we = 1'b1; dr_wdata = b;
    @(negedge clk); dr_we = 1'b0; empty_clr = 1'b1;
    @(negedge clk); empty_clr = 1'b0;
  endtask

  task automatic wait_end(output int k);
    k = 0;
    while (!end_flag && k < 2000) begin
      @(negedge clk); k++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int k, p0;
    logic [DW-1:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 empty", empty_flag, 1);
    chk("R1 end", end_flag, 1);
    chk("R1 txd", txd, 1);
    chk("R1 sck", sck_out, 1);
    chk("R3 irq_txe disabled", irq_txe, 0);
    chk("R8 irq_tend disabled", irq_tend, 0);
    txe_ie = 1'b1; tend_ie = 1'b1;
    @(negedge clk);
    chk("R3 irq_txe enabled", irq_txe, 1);
    chk("R8 irq_tend enabled", irq_tend, 1);

    // table of single frames, internal clock
    for (int i = 0; i < NV; i++) begin
      b = VEC[i][8:1];
      p0 = pulses;
      post(b);
      chk("R2 empty cleared", empty_flag, 0);
      chk("R3 irq_txe low", irq_txe, 0);
      @(negedge clk);
      chk("R2 empty set on load", empty_flag, 1);
      chk("R2 end cleared", end_flag, 0);
      chk("R2 bit0 out", txd, b[0]);
      chk("R5 sck falls on load", sck_out, 0);
      chk("R3 irq_txe on load", irq_txe, 1);
      wait_end(k);
      chk("R5 frame length", k, 16*H);
      chk("R5 pulse count", pulses - p0, 8);
      chk("R4 lsb first", cap[15:8], b);
      chk("R7 hold level", txd, VEC[i][0]);
      chk("R8 irq_tend", irq_tend, 1);
      repeat (10) @(negedge clk);
      chk("R7 txd held", txd, VEC[i][0]);
      chk("R7 sck parked", pulses - p0, 8);
    end

    // back-to-back frames and holding-register writes mid frame
    p0 = pulses;
    post(8'h96);
    @(negedge clk);
    dr_we = 1'b1; dr_wdata = 8'h5A;
    @(negedge clk); dr_we = 1'b0;
    chk("R10 frame unchanged by write", txd, 1'b0);
    empty_clr = 1'b1;
    @(negedge clk); empty_clr = 1'b0;
    k = 2;
    while (!end_flag && k < 2000) begin
      @(negedge clk); k++;
      if (k == 16*H) begin
        chk("R6 no end between frames", end_flag, 0);
        chk("R6 next bit0 at once", txd, 1'b0);
        chk("R6 sck falls at once", sck_out, 0);
      end
      if (k == 16*H + 2) begin dr_we = 1'b1; dr_wdata = 8'hE7; end
      if (k == 16*H + 3) dr_we = 1'b0;
    end
    chk("R6 two frame length", k, 32*H);
    chk("R6 pulses", pulses - p0, 16);
    chk("R6 data order", cap, 16'h5A96);
    repeat (40) @(negedge clk);
    chk("R10 write without clear sends nothing", pulses - p0, 16);
    chk("R10 end stays", end_flag, 1);

    // external clock
    ext_clk_sel = 1'b1;
    b = 8'h6C;
    p0 = pulses;
    post(b);
    @(negedge clk);
    chk("R9 bit0 loaded", txd, b[0]);
    repeat (10) @(negedge clk);
    chk("R9 idle clock no advance", txd, b[0]);
    chk("R9 sck_out high", sck_out, 1);
    for (int i = 0; i < DW; i++) begin
      sck_in = 1'b0;
      repeat (4) @(negedge clk);
      sck_in = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9 ext bit", txd, b[i]);
    end
    chk("R9 not ended before last fall", end_flag, 0);
    sck_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 ext end", end_flag, 1);
    chk("R7 ext hold", txd, b[7]);
    chk("R9 no internal pulses", pulses - p0, 0);
    ext_clk_sel = 1'b0; sck_in = 1'b1;
    tend_ie = 1'b0;
    @(negedge clk);
    chk("R8 irq_tend masked", irq_tend, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule